// File: doc/BRIEF.md
# Dual-Clock Two-Port Memory with Burst Address Counters

This block is a true two-port synchronous memory of `2**ADDR_W` words of `DATA_W` bits. The full-size setting is 14 address bits and 9 data bits; the default is smaller so the array stays cheap to elaborate. Each port has its own clock, reset, address, write data, read/write select, output enable and a pair of select inputs of opposite polarity. Either port may reach any word, and both ports may reach the same word in the same cycle.

Every port input is captured on the rising edge of that port's clock. The captured address goes into a per-port pointer register, which can also run as a burst counter. The pointer can be cleared, loaded from the address pins, stepped by one, or held. The access then takes place from the pointer on the following edge. Each port picks its own read latency with a strap input: one clock or two clocks after capture.

When both ports write the same word on the same edge, the left write is kept. A read that meets a write to the same word on the same edge returns the word as it was before that write. The collision rules apply when both ports run from one clock.

Top module: `dpr_counter_ram`

## Requirements
- R1: While reset is low, and after it is released, both pointers are 0 and both ports show `rd_vld` low and `rd_data` zero. A read issued with no pointer control therefore returns word 0.
- R2: A port is selected only when its `sel_lo_n` is 0 and its `sel_hi` is 1. A deselected port writes nothing, keeps its pointer unchanged whatever its pointer controls are, and yields `rd_vld` low.
- R3: On a selected port, `ptr_clr_n` = 0 sets the pointer to 0. This takes priority over load and step.
- R4: On a selected port, with clear inactive, `ptr_load_n` = 0 loads the pointer from `addr`. This takes priority over step.
- R5: On a selected port, with clear and load inactive, `ptr_step_n` = 0 adds one to the pointer. From the top word `2**ADDR_W-1` it wraps to 0.
- R6: On a selected port with no pointer control active, the pointer keeps its value. Repeated accesses reach the same word.
- R7: With `lat2` = 0, read data and `rd_vld` appear on the first rising edge after the edge that captured the command.
- R8: With `lat2` = 1, read data and `rd_vld` appear on the second rising edge after the capture edge. Each port's latency is independent of the other port's.
- R9: `rd_vld` is 1 only for a command that is selected, has `rd_wr` = 1 (read; 0 means write) and has `out_en_n` = 0. For every other command `rd_vld` is 0 and `rd_data` is zero.
- R10: When both ports write the same word on the same edge, the left port's data is stored.
- R11: A read on one port and a write on the other port to the same word on the same edge return the old contents. Later reads see the new contents.
- R12: Every word can be written and read back through either port, and both ports may read the same word on the same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_l | input | 1 | Left port clock |
| rst_l_n | input | 1 | Left port reset, active low, asynchronous |
| sel_lo_l_n | input | 1 | Left select, active low |
| sel_hi_l | input | 1 | Left select, active high |
| rd_wr_l | input | 1 | Left direction: 1 read, 0 write |
| out_en_l_n | input | 1 | Left output enable, active low |
| ptr_load_l_n | input | 1 | Left pointer load from `addr_l`, active low |
| ptr_step_l_n | input | 1 | Left pointer increment, active low |
| ptr_clr_l_n | input | 1 | Left pointer clear, active low |
| lat2_l | input | 1 | Left read latency: 0 one clock, 1 two clocks |
| addr_l | input | ADDR_W | Left address |
| wr_data_l | input | DATA_W | Left write data |
| rd_data_l | output | DATA_W | Left read data, zero when not valid |
| rd_vld_l | output | 1 | Left read data valid |
| clk_r | input | 1 | Right port clock |
| rst_r_n | input | 1 | Right port reset, active low, asynchronous |
| sel_lo_r_n | input | 1 | Right select, active low |
| sel_hi_r | input | 1 | Right select, active high |
| rd_wr_r | input | 1 | Right direction: 1 read, 0 write |
| out_en_r_n | input | 1 | Right output enable, active low |
| ptr_load_r_n | input | 1 | Right pointer load from `addr_r`, active low |
| ptr_step_r_n | input | 1 | Right pointer increment, active low |
| ptr_clr_r_n | input | 1 | Right pointer clear, active low |
| lat2_r | input | 1 | Right read latency: 0 one clock, 1 two clocks |
| addr_r | input | ADDR_W | Right address |
| wr_data_r | input | DATA_W | Right write data |
| rd_data_r | output | DATA_W | Right read data, zero when not valid |
| rd_vld_r | output | 1 | Right read data valid |

## Verification
Each command is driven on a falling edge and is captured on the next rising edge, k. The array is accessed on edge k+1. The port's outputs are due after edge k+1 with one-clock latency, or after edge k+2 with two-clock latency. The driver stamps every expected item with that edge number. It takes the number from the latency the port is strapped to, and reads the contents before the writes of the same edge, which gives R10 and R11. The monitor compares items on falling edges, once the stamped edge has passed, so it never samples while an output is still changing. Latency is changed only under reset, with the queues cleared, so no item is ever aged against the wrong pipeline depth.

// File: rtl/dpr_pkg.sv
package dpr_pkg;

  typedef enum logic [1:0] {
    PTR_HOLD,
    PTR_CLEAR,
    PTR_LOAD,
    PTR_STEP
  } ptr_op_e;

  // Clear beats load, load beats step; all controls active low.
  function automatic ptr_op_e ptr_decode(logic clr_n, logic load_n, logic step_n);
    if (!clr_n)  return PTR_CLEAR;
    if (!load_n) return PTR_LOAD;
    if (!step_n) return PTR_STEP;
    return PTR_HOLD;
  endfunction

  // Selected only with the low-true and high-true select both asserted.
  function automatic logic port_pick(logic sel_lo_n, logic sel_hi);
    return !sel_lo_n && sel_hi;
  endfunction

  // Live-value-table choice: equal tags mean the left bank is current.
  function automatic logic bank_is_right(logic tag_left, logic tag_right);
    return tag_left ^ tag_right;
  endfunction

endpackage

// File: rtl/dpr_port_front.sv
module dpr_port_front
  import dpr_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel_lo_n,
  input  logic              sel_hi,
  input  logic              rd_wr,
  input  logic              out_en_n,
  input  logic              ptr_load_n,
  input  logic              ptr_step_n,
  input  logic              ptr_clr_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [ADDR_W-1:0] ptr_q,
  output logic              wr_req_q,
  output logic              rd_req_q,
  output logic [DATA_W-1:0] wr_data_q
);

  localparam logic [ADDR_W-1:0] PTR_TOP = {ADDR_W{1'b1}};

  function automatic logic [ADDR_W-1:0] ptr_next(logic [ADDR_W-1:0] cur);
    return (cur == PTR_TOP) ? '0 : cur + 1'b1;
  endfunction

  logic    sel;
  ptr_op_e ptr_op;

  assign sel    = port_pick(sel_lo_n, sel_hi);
  assign ptr_op = ptr_decode(ptr_clr_n, ptr_load_n, ptr_step_n);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q     <= '0;
      wr_req_q  <= 1'b0;
      rd_req_q  <= 1'b0;
      wr_data_q <= '0;
    end else begin
      wr_req_q  <= sel && !rd_wr;
      rd_req_q  <= sel && rd_wr && !out_en_n;
      wr_data_q <= wr_data;
      if (sel) begin
        case (ptr_op)
          PTR_CLEAR: ptr_q <= '0;
          PTR_LOAD:  ptr_q <= addr;
          PTR_STEP:  ptr_q <= ptr_next(ptr_q);
          default:   ptr_q <= ptr_q;
        endcase
      end
    end
  end

  // R3
  ptr_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sel && !ptr_clr_n) |=> (ptr_q == '0));

  // R5
  ptr_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sel && ptr_clr_n && ptr_load_n && !ptr_step_n && (ptr_q == PTR_TOP)) |=> (ptr_q == '0));

  // R2
  desel_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sel |=> ($stable(ptr_q) && !wr_req_q && !rd_req_q));

  // R4
  ptr_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sel && ptr_clr_n && !ptr_load_n) |=> (ptr_q == $past(addr)));

endmodule

// File: rtl/dpr_lvt_array.sv
module dpr_lvt_array
  import dpr_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 9
) (
  input  logic              clk_l,
  input  logic              wr_l,
  input  logic              rd_l,
  input  logic [ADDR_W-1:0] addr_l,
  input  logic [DATA_W-1:0] wdata_l,
  output logic [DATA_W-1:0] rdata_l,
  input  logic              clk_r,
  input  logic              wr_r,
  input  logic              rd_r,
  input  logic [ADDR_W-1:0] addr_r,
  input  logic [DATA_W-1:0] wdata_r,
  output logic [DATA_W-1:0] rdata_r
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] bank_l [DEPTH];
  logic [DATA_W-1:0] bank_r [DEPTH];
  logic              tag_l  [DEPTH];
  logic              tag_r  [DEPTH];

  // Same-word write on the same edge: the right write is dropped.
  logic clash_wr;
  logic wr_r_kept;

  assign clash_wr  = wr_l && wr_r && (addr_l == addr_r);
  assign wr_r_kept = wr_r && !clash_wr;

  always_ff @(posedge clk_l) begin
    if (wr_l) begin
      bank_l[addr_l] <= wdata_l;
      tag_l[addr_l]  <= tag_r[addr_l];
    end
    if (rd_l) begin
      rdata_l <= bank_is_right(tag_l[addr_l], tag_r[addr_l]) ? bank_r[addr_l] : bank_l[addr_l];
    end
  end

  always_ff @(posedge clk_r) begin
    if (wr_r_kept) begin
      bank_r[addr_r] <= wdata_r;
      tag_r[addr_r]  <= !tag_l[addr_r];
    end
    if (rd_r) begin
      rdata_r <= bank_is_right(tag_l[addr_r], tag_r[addr_r]) ? bank_r[addr_r] : bank_l[addr_r];
    end
  end

  // R10
  clash_left_wins_chk: assert property (@(posedge clk_r)
    clash_wr |=> (tag_l[$past(addr_l)] == tag_r[$past(addr_l)]));

endmodule

// File: rtl/dpr_out_stage.sv
module dpr_out_stage #(
  parameter int DATA_W = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lat2,
  input  logic              rd_req_q,
  input  logic [DATA_W-1:0] rdata,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_vld
);

  logic              vld_s1;
  logic              vld_s2;
  logic [DATA_W-1:0] data_s2;
  logic [DATA_W-1:0] data_sel;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_s1  <= 1'b0;
      vld_s2  <= 1'b0;
      data_s2 <= '0;
    end else begin
      vld_s1  <= rd_req_q;
      vld_s2  <= vld_s1;
      data_s2 <= rdata;
    end
  end

  assign rd_vld   = lat2 ? vld_s2 : vld_s1;
  assign data_sel = lat2 ? data_s2 : rdata;
  assign rd_data  = rd_vld ? data_sel : '0;

  // R7
  one_clk_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req_q ##1 !lat2 |-> rd_vld);

  // R8
  two_clk_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req_q ##1 lat2 ##1 lat2 |-> rd_vld);

  // R9
  no_req_no_vld_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_req_q ##1 !lat2 |-> !rd_vld);

endmodule

// File: rtl/dpr_counter_ram.sv
module dpr_counter_ram
  import dpr_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 9
) (
  input  logic              clk_l,
  input  logic              rst_l_n,
  input  logic              sel_lo_l_n,
  input  logic              sel_hi_l,
  input  logic              rd_wr_l,
  input  logic              out_en_l_n,
  input  logic              ptr_load_l_n,
  input  logic              ptr_step_l_n,
  input  logic              ptr_clr_l_n,
  input  logic              lat2_l,
  input  logic [ADDR_W-1:0] addr_l,
  input  logic [DATA_W-1:0] wr_data_l,
  output logic [DATA_W-1:0] rd_data_l,
  output logic              rd_vld_l,
  input  logic              clk_r,
  input  logic              rst_r_n,
  input  logic              sel_lo_r_n,
  input  logic              sel_hi_r,
  input  logic              rd_wr_r,
  input  logic              out_en_r_n,
  input  logic              ptr_load_r_n,
  input  logic              ptr_step_r_n,
  input  logic              ptr_clr_r_n,
  input  logic              lat2_r,
  input  logic [ADDR_W-1:0] addr_r,
  input  logic [DATA_W-1:0] wr_data_r,
  output logic [DATA_W-1:0] rd_data_r,
  output logic              rd_vld_r
);

  localparam int NPORT = 2;

  logic              p_clk    [NPORT];
  logic              p_rst_n  [NPORT];
  logic              p_sel_lo [NPORT];
  logic              p_sel_hi [NPORT];
  logic              p_rd_wr  [NPORT];
  logic              p_oe_n   [NPORT];
  logic              p_load_n [NPORT];
  logic              p_step_n [NPORT];
  logic              p_clr_n  [NPORT];
  logic              p_lat2   [NPORT];
  logic [ADDR_W-1:0] p_addr   [NPORT];
  logic [DATA_W-1:0] p_wdata  [NPORT];

  // Named internal events shared between the pieces.
  logic [ADDR_W-1:0] ptr_q    [NPORT];
  logic              wr_req_q [NPORT];
  logic              rd_req_q [NPORT];
  logic [DATA_W-1:0] wdata_q  [NPORT];
  logic [DATA_W-1:0] arr_rd   [NPORT];
  logic [DATA_W-1:0] out_data [NPORT];
  logic              out_vld  [NPORT];

  assign p_clk[0]    = clk_l;        assign p_clk[1]    = clk_r;
  assign p_rst_n[0]  = rst_l_n;      assign p_rst_n[1]  = rst_r_n;
  assign p_sel_lo[0] = sel_lo_l_n;   assign p_sel_lo[1] = sel_lo_r_n;
  assign p_sel_hi[0] = sel_hi_l;     assign p_sel_hi[1] = sel_hi_r;
  assign p_rd_wr[0]  = rd_wr_l;      assign p_rd_wr[1]  = rd_wr_r;
  assign p_oe_n[0]   = out_en_l_n;   assign p_oe_n[1]   = out_en_r_n;
  assign p_load_n[0] = ptr_load_l_n; assign p_load_n[1] = ptr_load_r_n;
  assign p_step_n[0] = ptr_step_l_n; assign p_step_n[1] = ptr_step_r_n;
  assign p_clr_n[0]  = ptr_clr_l_n;  assign p_clr_n[1]  = ptr_clr_r_n;
  assign p_lat2[0]   = lat2_l;       assign p_lat2[1]   = lat2_r;
  assign p_addr[0]   = addr_l;       assign p_addr[1]   = addr_r;
  assign p_wdata[0]  = wr_data_l;    assign p_wdata[1]  = wr_data_r;

  for (genvar p = 0; p < NPORT; p++) begin : g_port
    dpr_port_front #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_front (
      .clk        (p_clk[p]),
      .rst_n      (p_rst_n[p]),
      .sel_lo_n   (p_sel_lo[p]),
      .sel_hi     (p_sel_hi[p]),
      .rd_wr      (p_rd_wr[p]),
      .out_en_n   (p_oe_n[p]),
      .ptr_load_n (p_load_n[p]),
      .ptr_step_n (p_step_n[p]),
      .ptr_clr_n  (p_clr_n[p]),
      .addr       (p_addr[p]),
      .wr_data    (p_wdata[p]),
      .ptr_q      (ptr_q[p]),
      .wr_req_q   (wr_req_q[p]),
      .rd_req_q   (rd_req_q[p]),
      .wr_data_q  (wdata_q[p])
    );

    dpr_out_stage #(.DATA_W(DATA_W)) u_out (
      .clk      (p_clk[p]),
      .rst_n    (p_rst_n[p]),
      .lat2     (p_lat2[p]),
      .rd_req_q (rd_req_q[p]),
      .rdata    (arr_rd[p]),
      .rd_data  (out_data[p]),
      .rd_vld   (out_vld[p])
    );
  end

  dpr_lvt_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_array (
    .clk_l   (p_clk[0]),
    .wr_l    (wr_req_q[0]),
    .rd_l    (rd_req_q[0]),
    .addr_l  (ptr_q[0]),
    .wdata_l (wdata_q[0]),
    .rdata_l (arr_rd[0]),
    .clk_r   (p_clk[1]),
    .wr_r    (wr_req_q[1]),
    .rd_r    (rd_req_q[1]),
    .addr_r  (ptr_q[1]),
    .wdata_r (wdata_q[1]),
    .rdata_r (arr_rd[1])
  );

  assign rd_data_l = out_data[0];
  assign rd_vld_l  = out_vld[0];
  assign rd_data_r = out_data[1];
  assign rd_vld_r  = out_vld[1];

endmodule

// File: tb/tb_dpr_counter_ram.sv
module tb_dpr_counter_ram;

  localparam int AW    = 10;
  localparam int DW    = 9;
  localparam int DEPTH = 1 << AW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic          sel_lo_l_n, sel_hi_l, rd_wr_l, out_en_l_n, ptr_load_l_n, ptr_step_l_n, ptr_clr_l_n, lat2_l;
  logic          sel_lo_r_n, sel_hi_r, rd_wr_r, out_en_r_n, ptr_load_r_n, ptr_step_r_n, ptr_clr_r_n, lat2_r;
  logic [AW-1:0] addr_l, addr_r;
  logic [DW-1:0] wr_data_l, wr_data_r, rd_data_l, rd_data_r;
  logic          rd_vld_l, rd_vld_r;

  dpr_counter_ram #(.ADDR_W(AW), .DATA_W(DW)) dut (
    .clk_l(clk), .rst_l_n(rst_n), .sel_lo_l_n(sel_lo_l_n), .sel_hi_l(sel_hi_l),
    .rd_wr_l(rd_wr_l), .out_en_l_n(out_en_l_n), .ptr_load_l_n(ptr_load_l_n),
    .ptr_step_l_n(ptr_step_l_n), .ptr_clr_l_n(ptr_clr_l_n), .lat2_l(lat2_l),
    .addr_l(addr_l), .wr_data_l(wr_data_l), .rd_data_l(rd_data_l), .rd_vld_l(rd_vld_l),
    .clk_r(clk), .rst_r_n(rst_n), .sel_lo_r_n(sel_lo_r_n), .sel_hi_r(sel_hi_r),
    .rd_wr_r(rd_wr_r), .out_en_r_n(out_en_r_n), .ptr_load_r_n(ptr_load_r_n),
    .ptr_step_r_n(ptr_step_r_n), .ptr_clr_r_n(ptr_clr_r_n), .lat2_r(lat2_r),
    .addr_r(addr_r), .wr_data_r(wr_data_r), .rd_data_r(rd_data_r), .rd_vld_r(rd_vld_r)
  );

  typedef struct {
    bit            en;
    bit            alt;
    bit            clr;
    bit            load;
    bit            stp;
    bit            rd;
    bit            oe;
    logic [AW-1:0] a;
    logic [DW-1:0] d;
  } cmd_t;

  typedef struct {
    int            due;
    logic          v;
    logic [DW-1:0] d;
    string         tag;
  } exp_t;

  exp_t          q_l[$];
  exp_t          q_r[$];
  logic [DW-1:0] model [DEPTH];
  logic [AW-1:0] ptr_l, ptr_r;
  int            lat_l, lat_r;
  int            cyc = 0;
  int            checks = 0;
  int            bad = 0;
  bit            done = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic cmd_t mk(bit clr, bit load, bit stp, bit rd, bit oe, int a, int d);
    cmd_t c;
    c.en = 1'b1; c.alt = 1'b0; c.clr = clr; c.load = load; c.stp = stp;
    c.rd = rd; c.oe = oe; c.a = AW'(a); c.d = DW'(d);
    return c;
  endfunction

  function automatic cmd_t off(bit alt, bit clr, bit load, bit stp, bit rd, int a, int d);
    cmd_t c;
    c = mk(clr, load, stp, rd, 1'b1, a, d);
    c.en = 1'b0; c.alt = alt;
    return c;
  endfunction

  function automatic cmd_t idle();
    return mk(1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 0, 0);
  endfunction

  function automatic int fdat(int i);
    return (i * 37 + 5) % 512;
  endfunction

  // Bench pointer model: clear, then load, then step with wrap, else hold.
  function automatic logic [AW-1:0] nxt(logic [AW-1:0] p, cmd_t c);
    if (!c.en)  return p;
    if (c.clr)  return '0;
    if (c.load) return c.a;
    if (c.stp)  return AW'((int'(p) + 1) % DEPTH);
    return p;
  endfunction

  task automatic check(string tag, string port, logic v_act, logic [DW-1:0] d_act,
                       logic v_exp, logic [DW-1:0] d_exp);
    checks++;
    if (v_act !== v_exp || d_act !== d_exp) begin
      bad++;
      $display("FAIL %s port %s: got vld=%0b data=%h, expected vld=%0b data=%h",
               tag, port, v_act, d_act, v_exp, d_exp);
    end
  endtask

  task automatic drive_pins(cmd_t l, cmd_t r);
    sel_lo_l_n   = l.en ? 1'b0 : !l.alt;
    sel_hi_l     = l.en ? 1'b1 : !l.alt;
    rd_wr_l      = l.rd;
    out_en_l_n   = !l.oe;
    ptr_load_l_n = !l.load;
    ptr_step_l_n = !l.stp;
    ptr_clr_l_n  = !l.clr;
    addr_l       = l.a;
    wr_data_l    = l.d;
    sel_lo_r_n   = r.en ? 1'b0 : !r.alt;
    sel_hi_r     = r.en ? 1'b1 : !r.alt;
    rd_wr_r      = r.rd;
    out_en_r_n   = !r.oe;
    ptr_load_r_n = !r.load;
    ptr_step_r_n = !r.stp;
    ptr_clr_r_n  = !r.clr;
    addr_r       = r.a;
    wr_data_r    = r.d;
  endtask

  // Driver: one command per port per cycle, expected items pushed to the scoreboard.
  task automatic step(cmd_t l, cmd_t r, string tag);
    exp_t el, er;
    @(negedge clk);
    drive_pins(l, r);
    ptr_l = nxt(ptr_l, l);
    ptr_r = nxt(ptr_r, r);
    el.due = cyc + 1 + lat_l;
    el.v   = l.en && l.rd && l.oe;
    el.d   = el.v ? model[ptr_l] : '0;
    el.tag = tag;
    er.due = cyc + 1 + lat_r;
    er.v   = r.en && r.rd && r.oe;
    er.d   = er.v ? model[ptr_r] : '0;
    er.tag = tag;
    // R10: right written first so the left write overrides it.
    if (r.en && !r.rd) model[ptr_r] = r.d;
    if (l.en && !l.rd) model[ptr_l] = l.d;
    q_l.push_back(el);
    q_r.push_back(er);
  endtask

  // Monitor: pops items whose due edge has passed.
  always @(negedge clk) begin
    if (rst_n) begin
      while (q_l.size() > 0 && q_l[0].due <= cyc) begin
        exp_t e;
        e = q_l.pop_front();
        check(e.tag, "L", rd_vld_l, rd_data_l, e.v, e.d);
      end
      while (q_r.size() > 0 && q_r[0].due <= cyc) begin
        exp_t e;
        e = q_r.pop_front();
        check(e.tag, "R", rd_vld_r, rd_data_r, e.v, e.d);
      end
    end
  end

  task automatic do_reset(bit l2, bit r2);
    @(negedge clk);
    rst_n = 1'b0;
    drive_pins(idle(), idle());
    lat2_l = l2; lat2_r = r2;
    lat_l = l2 ? 2 : 1;
    lat_r = r2 ? 2 : 1;
    q_l.delete(); q_r.delete();
    ptr_l = '0; ptr_r = '0;
    repeat (3) @(negedge clk);
    // R1: outputs held low in reset
    check("R1 reset", "L", rd_vld_l, rd_data_l, 1'b0, '0);
    check("R1 reset", "R", rd_vld_r, rd_data_r, 1'b0, '0);
    rst_n = 1'b1;
  endtask

  task automatic drain();
    repeat (4) step(idle(), idle(), "R9 idle");
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; bad++;
      $display("FAIL watchdog: run hung, got done=0 expected done=1");
      $display("  test done: total=%0d bad=%0d", checks, bad);
      $finish;
    end
  end

  initial begin : main
    drive_pins(idle(), idle());
    lat2_l = 1'b0; lat2_r = 1'b1;
    lat_l = 1; lat_r = 2;
    ptr_l = '0; ptr_r = '0;

    // Phase 1: left one-clock, right two-clock latency.
    do_reset(1'b0, 1'b1);

    // R12 / R5: fill every word from the left with a load then steps; writes give no valid (R9).
    step(mk(0, 1, 0, 0, 1, 0, fdat(0)), idle(), "R12 fill write");
    for (int i = 1; i < DEPTH; i++)
      step(mk(0, 0, 1, 0, 1, 0, fdat(i)), idle(), "R5 fill step");

    // R12 / R8: read all back from the right, then one more step wraps to 0 (R5).
    step(idle(), mk(0, 1, 0, 1, 1, 0, 0), "R12 readback");
    for (int i = 1; i < DEPTH; i++)
      step(idle(), mk(0, 0, 1, 1, 1, 0, 0), "R8 readback step");
    step(idle(), mk(0, 0, 1, 1, 1, 0, 0), "R5 wrap to 0");

    // R12: both ports read the same word on the same edge; R7 left latency.
    step(mk(0, 1, 0, 1, 1, 77, 0), mk(0, 1, 0, 1, 1, 77, 0), "R12 same-word read");
    step(mk(0, 0, 1, 1, 1, 0, 0), mk(0, 0, 1, 1, 1, 0, 0), "R7 burst read");

    // R9: read with output enable off.
    step(mk(0, 1, 0, 1, 0, 12, 0), idle(), "R9 oe off");
    step(mk(0, 0, 1, 1, 0, 0, 0), idle(), "R9 oe off step");

    // R2: park pointer at 5, then deselect both ways with writes and pointer controls.
    step(mk(0, 1, 0, 1, 1, 5, 0), idle(), "R2 park");
    step(off(1'b0, 0, 1, 0, 0, 9, 9'h1AA), idle(), "R2 desel lo");
    step(off(1'b1, 1, 0, 1, 0, 9, 9'h155), idle(), "R2 desel hi");
    step(off(1'b0, 0, 0, 1, 1, 0, 0), idle(), "R2 desel read");
    step(mk(0, 0, 0, 1, 1, 0, 0), idle(), "R2 pointer frozen");
    step(mk(0, 1, 0, 1, 1, 9, 0), idle(), "R2 no write");

    // R3: clear wins over load and step.
    step(mk(1, 1, 1, 1, 1, 300, 0), idle(), "R3 clear priority");
    // R4: load wins over step.
    step(mk(0, 1, 1, 1, 1, 20, 0), idle(), "R4 load priority");
    step(mk(0, 0, 1, 1, 1, 0, 0), idle(), "R5 step after load");
    // R6: no control holds the pointer.
    step(mk(0, 0, 0, 1, 1, 999, 0), idle(), "R6 hold");
    step(mk(0, 0, 0, 1, 1, 3, 0), idle(), "R6 hold again");

    // R10: both write word 33 on one edge; left data kept.
    step(mk(0, 1, 0, 0, 1, 33, 9'h055), mk(0, 1, 0, 0, 1, 33, 9'h1F0), "R10 clash write");
    step(mk(0, 0, 0, 1, 1, 0, 0), mk(0, 0, 0, 1, 1, 0, 0), "R10 left wins");

    // R11: write on one port meets read on the other, both directions.
    step(mk(0, 1, 0, 0, 1, 40, 9'h0C3), mk(0, 1, 0, 1, 1, 40, 0), "R11 old data R");
    step(idle(), mk(0, 0, 0, 1, 1, 0, 0), "R11 new data R");
    step(mk(0, 1, 0, 1, 1, 41, 0), mk(0, 1, 0, 0, 1, 41, 9'h13C), "R11 old data L");
    step(mk(0, 0, 0, 1, 1, 0, 0), idle(), "R11 new data L");
    drain();

    // Phase 2: latencies swapped.
    do_reset(1'b1, 1'b0);
    step(mk(0, 0, 0, 1, 1, 500, 0), mk(0, 0, 0, 1, 1, 600, 0), "R1 pointer zero");
    step(mk(0, 1, 0, 1, 1, DEPTH - 2, 0), mk(0, 1, 0, 1, 1, 100, 0), "R8 load read");
    for (int i = 0; i < 4; i++)
      step(mk(0, 0, 1, 1, 1, 0, 0), mk(0, 0, 1, 1, 1, 0, 0), "R7 burst swap");
    step(mk(0, 0, 0, 1, 0, 0, 0), mk(0, 0, 0, 1, 1, 0, 0), "R9 mixed oe");
    step(mk(0, 1, 0, 0, 1, 7, 9'h0AB), mk(0, 1, 0, 1, 1, 7, 0), "R11 swap old");
    step(mk(0, 0, 0, 1, 1, 0, 0), mk(0, 0, 0, 1, 1, 0, 0), "R12 swap new");
    drain();

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

endmodule